// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller with Inter-Processor Interrupts

This block collects interrupt requests for a small group of processors. Rising edges on the hardware request lines latch into one shared in-service vector of up to 64 bits. Each processor owns a mask register, and each processor gets its own interrupt line. That line is high whenever a bit that is both in service and enabled in that processor's mask is present.

Software reaches the controller through one register port that is shared by all processors. Each access carries the number of the processor that issues it. The in-service vector has three views:
- a set-only view, through which software raises interrupts, and in particular sends inter-processor interrupts;
- a clear-only view, through which handlers retire finished interrupts;
- a read-only view, which returns the full vector.

An identity register returns the number of the processor that performs the read. Four IRQ numbers, starting at a base parameter, are reserved for inter-processor interrupts. After reset, IRQ base+n is enabled only in the mask of processor n.

Writes take effect at the clock edge that accepts them. A read returns its data one cycle after the request, marked by a response strobe. Reads may be issued back to back.

The port logic is built around a two-state machine:
- IDLE: no read response is pending. A read request moves it to RESP. Any other cycle keeps it in IDLE.
- RESP: read data is presented with the strobe high. A further read keeps it in RESP. Otherwise it returns to IDLE.

Top module: `mpirq_ctrl`

## Requirements
- R1: After reset the in-service vector is zero, every interrupt line is low, and the response strobe is low. The mask of processor n holds only bit IPI_BASE+n (bit 46+n with default parameters).
- R2: Register offsets 0 to NUM_CPU-1 are the per-processor masks, one IRQ per bit. A write replaces the mask whole, and a read returns the last value written.
- R3: A write to offset 4 (set view) sets every in-service bit where the written data is one. Bits written as zero keep their value.
- R4: A write to offset 5 (clear view) clears every in-service bit where the written data is one. Bits written as zero keep their value.
- R5: A read of offset 6 returns the in-service vector. Writes to offset 6 and offset 7 change no state.
- R6: A read of offset 7 returns the number of the requesting processor, taken from req_cpu, zero-extended.
- R7: A rising edge on hw_irq[i] sets in-service bit i. A request line that stays high does not set the bit again after it has been cleared.
- R8: When a hardware rising edge and a clear-view write reach the same bit in the same cycle, the bit ends up set.
- R9: cpu_irq[n] is high exactly when (in-service AND mask of processor n) is non-zero. It follows the vector in the same cycle the vector changes.
- R10: With reset masks, setting bit IPI_BASE+n raises cpu_irq[n] alone.
- R11: A read request gives rd_valid high with its data in the next cycle, and back-to-back reads give back-to-back responses. Reads of offsets 4 and 5 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq | input | NUM_IRQ | Hardware request lines, rising-edge sensitive |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | CPU_W | Number of the requesting processor |
| req_addr | input | 3 | Register offset |
| req_wdata | input | NUM_IRQ | Write data |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | NUM_IRQ | Read response data |
| cpu_irq | output | NUM_CPU | Interrupt line for each processor |

## Verification
The bench builds the block with its default parameters: four processors, 64 IRQ bits and an inter-processor base of 46. With these values every mask register and every processor's inter-processor bit is reachable, and so is the top of the vector. The directed scenarios cover the following:
- partial set and clear patterns;
- mask steering to each interrupt line;
- ignored writes to the read-only offsets;
- level-held hardware requests;
- the same-cycle collision of a hardware edge with a clear write, where set has priority.

// File: rtl/mpirq_pkg.sv
package mpirq_pkg;

    localparam int unsigned ADDR_W     = 3;
    localparam int unsigned OFS_SET    = 4;
    localparam int unsigned OFS_CLR    = 5;
    localparam int unsigned OFS_STATUS = 6;
    localparam int unsigned OFS_IDENT  = 7;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } port_state_e;

    typedef enum logic [2:0] {
        RK_MASK,
        RK_SET,
        RK_CLR,
        RK_STATUS,
        RK_IDENT,
        RK_NONE
    } reg_kind_e;

    function automatic reg_kind_e decode_offset(input logic [ADDR_W-1:0] ofs,
                                                input int unsigned num_cpu);
        reg_kind_e k;
        if (32'(ofs) < num_cpu)                k = RK_MASK;
        else if (32'(ofs) == OFS_SET)          k = RK_SET;
        else if (32'(ofs) == OFS_CLR)          k = RK_CLR;
        else if (32'(ofs) == OFS_STATUS)       k = RK_STATUS;
        else if (32'(ofs) == OFS_IDENT)        k = RK_IDENT;
        else                                   k = RK_NONE;
        return k;
    endfunction

endpackage

// File: rtl/mpirq_edge.sv
module mpirq_edge #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    output logic [W-1:0] rise
);
    logic [W-1:0] level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/mpirq_isr.sv
module mpirq_isr #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] status
);
    logic [W-1:0] status_d;

    // Clear is applied first, then set, so a set reaching the same bit wins.
    always_comb status_d = (status & ~clr_vec) | set_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status <= '0;
        else        status <= status_d;
    end
endmodule

// File: rtl/mpirq_mask_bank.sv
module mpirq_mask_bank #(
    parameter int unsigned NUM_CPU  = 4,
    parameter int unsigned W        = 64,
    parameter int unsigned IPI_BASE = 46
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CPU-1:0]   mask_we,
    input  logic [W-1:0]         wdata,
    input  logic [W-1:0]         status,
    output logic [NUM_CPU*W-1:0] masks,
    output logic [NUM_CPU-1:0]   irq_out
);
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        localparam logic [W-1:0] RST_MASK = W'(1) << (IPI_BASE + c);
        logic [W-1:0] mask_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          mask_q <= RST_MASK;
            else if (mask_we[c]) mask_q <= wdata;
        end

        assign masks[c*W +: W] = mask_q;
        assign irq_out[c]      = |(status & mask_q);
    end
endmodule

// File: rtl/mpirq_port.sv
module mpirq_port
    import mpirq_pkg::*;
#(
    parameter int unsigned NUM_CPU = 4,
    parameter int unsigned W       = 64,
    parameter int unsigned CPU_W   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [CPU_W-1:0]     req_cpu,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [W-1:0]         req_wdata,
    input  logic [W-1:0]         status,
    input  logic [NUM_CPU*W-1:0] masks,
    output logic [W-1:0]         sw_set,
    output logic [W-1:0]         sw_clr,
    output logic [NUM_CPU-1:0]   mask_we,
    output logic                 rd_valid,
    output logic [W-1:0]         rd_data
);
    port_state_e state_q, state_d;
    reg_kind_e   kind;
    logic        is_wr, is_rd;
    logic [W-1:0] rd_mux;

    assign kind  = decode_offset(req_addr, NUM_CPU);
    assign is_wr = req_valid &&  req_write;
    assign is_rd = req_valid && !req_write;

    // Write strobes
    always_comb begin
        sw_set  = '0;
        sw_clr  = '0;
        mask_we = '0;
        if (is_wr) begin
            unique case (kind)
                RK_SET:  sw_set = req_wdata;
                RK_CLR:  sw_clr = req_wdata;
                RK_MASK: mask_we[req_addr[CPU_W-1:0]] = 1'b1;
                default: ;
            endcase
        end
    end

    // Read multiplexer
    always_comb begin
        rd_mux = '0;
        unique case (kind)
            RK_MASK:   rd_mux = masks[req_addr[CPU_W-1:0]*W +: W];
            RK_STATUS: rd_mux = status;
            RK_IDENT:  rd_mux = W'(req_cpu);
            default:   rd_mux = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (is_rd) state_d = ST_RESP;
            ST_RESP: state_d = is_rd ? ST_RESP : ST_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (is_rd) rd_data <= rd_mux;
    end

    assign rd_valid = (state_q == ST_RESP);
endmodule

// File: rtl/mpirq_ctrl.sv
module mpirq_ctrl
    import mpirq_pkg::*;
#(
    parameter int unsigned NUM_CPU  = 4,
    parameter int unsigned NUM_IRQ  = 64,
    parameter int unsigned IPI_BASE = 46,
    localparam int unsigned CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] hw_irq,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [CPU_W-1:0]   req_cpu,
    input  logic [2:0]         req_addr,
    input  logic [NUM_IRQ-1:0] req_wdata,
    output logic               rd_valid,
    output logic [NUM_IRQ-1:0] rd_data,
    output logic [NUM_CPU-1:0] cpu_irq
);
    logic [NUM_IRQ-1:0]         hw_edge;
    logic [NUM_IRQ-1:0]         sw_set, sw_clr;
    logic [NUM_IRQ-1:0]         status;
    logic [NUM_CPU-1:0]         mask_we;
    logic [NUM_CPU*NUM_IRQ-1:0] masks;

    mpirq_edge #(.W(NUM_IRQ)) u_edge (
        .clk(clk), .rst_n(rst_n), .level(hw_irq), .rise(hw_edge)
    );

    mpirq_isr #(.W(NUM_IRQ)) u_isr (
        .clk(clk), .rst_n(rst_n),
        .set_vec(sw_set | hw_edge), .clr_vec(sw_clr), .status(status)
    );

    mpirq_mask_bank #(.NUM_CPU(NUM_CPU), .W(NUM_IRQ), .IPI_BASE(IPI_BASE)) u_masks (
        .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .wdata(req_wdata),
        .status(status), .masks(masks), .irq_out(cpu_irq)
    );

    mpirq_port #(.NUM_CPU(NUM_CPU), .W(NUM_IRQ), .CPU_W(CPU_W)) u_port (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_cpu(req_cpu), .req_addr(req_addr), .req_wdata(req_wdata),
        .status(status), .masks(masks), .sw_set(sw_set), .sw_clr(sw_clr),
        .mask_we(mask_we), .rd_valid(rd_valid), .rd_data(rd_data)
    );
endmodule

// File: rtl/mpirq_ctrl_chk.sv
module mpirq_ctrl_chk
    import mpirq_pkg::*;
#(
    parameter int unsigned NUM_CPU = 4,
    parameter int unsigned NUM_IRQ = 64,
    parameter int unsigned CPU_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic [CPU_W-1:0]   req_cpu,
    input logic [2:0]         req_addr,
    input logic [NUM_IRQ-1:0] req_wdata,
    input logic [NUM_IRQ-1:0] hw_edge,
    input logic [NUM_IRQ-1:0] status,
    input logic               rd_valid,
    input logic [NUM_IRQ-1:0] rd_data,
    input logic [NUM_CPU-1:0] cpu_irq
);
    logic set_wr, clr_wr, id_rd, any_rd;
    assign set_wr = req_valid && req_write && (32'(req_addr) == OFS_SET);
    assign clr_wr = req_valid && req_write && (32'(req_addr) == OFS_CLR);
    assign id_rd  = req_valid && !req_write && (32'(req_addr) == OFS_IDENT);
    assign any_rd = req_valid && !req_write;

    // R3
    set_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((status & $past(req_wdata)) == $past(req_wdata)));

    // R4
    clr_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((status & $past(req_wdata) & ~$past(hw_edge)) == '0));

    // R4
    zero_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wr || clr_wr) |=>
            ((status & ~$past(req_wdata) & ~$past(hw_edge)) ==
             ($past(status) & ~$past(req_wdata) & ~$past(hw_edge))));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && (|hw_edge)) |=> ((status & $past(hw_edge)) == $past(hw_edge)));

    // R6
    ident_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_rd |=> (rd_valid && (rd_data == NUM_IRQ'($past(req_cpu)))));

    // R11
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_rd |=> rd_valid);

    // R11
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_rd |=> !rd_valid);

    // R9
    quiet_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> (cpu_irq == '0));
endmodule

bind mpirq_ctrl mpirq_ctrl_chk #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .CPU_W(CPU_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_cpu(req_cpu), .req_addr(req_addr), .req_wdata(req_wdata),
    .hw_edge(hw_edge), .status(status), .rd_valid(rd_valid), .rd_data(rd_data),
    .cpu_irq(cpu_irq)
);

// File: tb/mpirq_ctrl_bench.sv
module mpirq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU = 4;
    localparam int NIRQ = 64;
    localparam int IPIB = 46;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NIRQ-1:0] hw_irq = '0;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [1:0]      req_cpu = '0;
    logic [2:0]      req_addr = '0;
    logic [NIRQ-1:0] req_wdata = '0;
    logic            rd_valid;
    logic [NIRQ-1:0] rd_data;
    logic [NCPU-1:0] cpu_irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpirq_ctrl u_mpirq_ctrl (
        .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .req_valid(req_valid),
        .req_write(req_write), .req_cpu(req_cpu), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .cpu_irq(cpu_irq)
    );

    task automatic check(input string req, input logic [NIRQ-1:0] act,
                         input logic [NIRQ-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] cpu, input logic [2:0] ofs,
                      input logic [NIRQ-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_cpu = cpu;
        req_addr = ofs; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [1:0] cpu, input logic [2:0] ofs,
                      output logic [NIRQ-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_cpu = cpu; req_addr = ofs;
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 rd_valid", {63'd0, rd_valid}, 64'd1);
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [NIRQ-1:0] v;
        check("R1 rd_valid", {63'd0, rd_valid}, 64'd0);
        check("R1 cpu_irq", {60'd0, cpu_irq}, 64'd0);
        rd(0, 6, v);
        check("R1 status", v, 64'd0);
        for (int c = 0; c < NCPU; c++) begin
            rd(2'(c), 3'(c), v);
            check("R1 reset mask", v, 64'd1 << (IPIB + c));
        end
    endtask

    task automatic t_ipi();
        for (int c = 0; c < NCPU; c++) begin
            wr(2'(3 - c), 4, 64'd1 << (IPIB + c));
            check("R10 ipi target", {60'd0, cpu_irq}, 64'd1 << c);
            wr(2'(c), 5, 64'd1 << (IPIB + c));
            check("R4 ipi retired", {60'd0, cpu_irq}, 64'd0);
        end
    endtask

    task automatic t_set_clr();
        logic [NIRQ-1:0] v;
        logic [NIRQ-1:0] a = 64'h8000_0000_0000_00F1;
        logic [NIRQ-1:0] b = 64'h0000_0F00_0000_0300;
        logic [NIRQ-1:0] c = 64'h8000_0000_0000_0201;
        wr(0, 4, a);
        wr(1, 4, b);
        rd(0, 6, v);
        check("R3 set accumulate", v, a | b);
        wr(2, 5, c);
        rd(0, 6, v);
        check("R4 partial clear", v, (a | b) & ~c);
        check("R9 masked off", {60'd0, cpu_irq}, 64'd0);
        wr(0, 5, '1);
        rd(0, 6, v);
        check("R4 clear all", v, 64'd0);
    endtask

    task automatic t_mask();
        logic [NIRQ-1:0] v;
        wr(1, 1, 64'h0000_0000_0000_0008);
        wr(0, 2, '1);
        rd(3, 1, v);
        check("R2 mask1 readback", v, 64'h8);
        rd(3, 2, v);
        check("R2 mask2 readback", v, '1);
        check("R9 empty status", {60'd0, cpu_irq}, 64'd0);
        wr(0, 4, 64'h8);
        check("R9 steer bit3", {60'd0, cpu_irq}, 64'b0110);
        wr(0, 4, 64'd1 << (IPIB + 3));
        check("R9 steer ipi3", {60'd0, cpu_irq}, 64'b1110);
        wr(0, 5, '1);
        wr(0, 1, 64'd1 << (IPIB + 1));
        wr(0, 2, 64'd1 << (IPIB + 2));
    endtask

    task automatic t_readonly();
        logic [NIRQ-1:0] v;
        wr(0, 4, 64'h55);
        wr(1, 6, '1);
        wr(2, 7, '1);
        rd(0, 6, v);
        check("R5 status unchanged", v, 64'h55);
        for (int c = 0; c < NCPU; c++) begin
            rd(2'(c), 7, v);
            check("R6 identity", v, 64'(c));
        end
        rd(0, 4, v);
        check("R11 set view reads 0", v, 64'd0);
        rd(0, 5, v);
        check("R11 clr view reads 0", v, 64'd0);
        wr(0, 5, 64'h55);
    endtask

    task automatic t_hw();
        logic [NIRQ-1:0] v;
        @(negedge clk); hw_irq[10] = 1'b1;
        rd(0, 6, v);
        check("R7 edge sets", v, 64'd1 << 10);
        wr(0, 5, 64'd1 << 10);
        @(negedge clk);
        rd(0, 6, v);
        check("R7 held level no reset", v, 64'd0);
        @(negedge clk); hw_irq[10] = 1'b0;
        @(negedge clk); hw_irq[10] = 1'b1;
        rd(0, 6, v);
        check("R7 new edge sets", v, 64'd1 << 10);
        wr(0, 5, 64'd1 << 10);
        // R8: collision of hw edge on bit 20 with clear write of bit 20
        wr(0, 4, 64'd1 << 20);
        @(negedge clk);
        hw_irq[20] = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 5; req_wdata = 64'd1 << 20;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        rd(0, 6, v);
        check("R8 set wins", v, 64'd1 << 20);
        wr(0, 5, 64'd1 << 20);
        rd(0, 6, v);
        check("R8 later clear", v, 64'd0);
    endtask

    task automatic t_b2b();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_cpu = 2; req_addr = 7;
        @(negedge clk);
        check("R11 b2b first valid", {63'd0, rd_valid}, 64'd1);
        check("R11 b2b first data", rd_data, 64'd2);
        req_cpu = 3;
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 b2b second valid", {63'd0, rd_valid}, 64'd1);
        check("R11 b2b second data", rd_data, 64'd3);
        @(negedge clk);
        check("R11 strobe drops", {63'd0, rd_valid}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ipi();
        t_set_clr();
        t_mask();
        t_readonly();
        t_hw();
        t_b2b();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule